// File: doc/BRIEF.md
# Selectable-Order Decimating Low-Pass Filter

This block sits after a quadrature mixer and reduces the sample rate of the I and Q streams while low-pass filtering them. A two-bit mode input picks the filter structure at run time: a three-stage cascaded integrator-comb filter, a single accumulator that sums a window of samples and then starts over (integrate-and-dump), or a straight pass-through. Both lanes share one decimation controller, so I and Q outputs always appear together.

The output instants come from one of two sources. A programmed count emits one output per count of valid input samples. Alternatively, an external strobe from a resampling oscillator marks the input samples on which an output is taken, which lets a symbol timing loop align outputs with symbol boundaries. Filtered values are scaled by a programmable right shift and rounded. The result is then saturated to a 10-bit signed output, and a one-clock ready pulse marks it.

Top module: `cic_decim_top`

## Requirements
- R1: After reset, out_valid is 0 and out_i and out_q are 0.
- R2: Mode encoding: 2'b00 selects the three-stage integrator-comb filter, 2'b01 selects integrate-and-dump, and both 2'b10 and 2'b11 select pass-through.
- R3: In pass-through, out_valid equals in_valid one clock later, and each valid input pair appears unchanged at the outputs one clock later. shift, dec_count, use_strobe and strobe have no effect.
- R4: With use_strobe=0, a dump happens on a valid sample when the count of valid samples since the last dump (or since reset) is dec_count-1. The result is one output for every dec_count valid samples, for any dec_count from 1 to 4096. The first output comes on the dec_count-th valid sample after reset. strobe is ignored.
- R5: With use_strobe=1, a dump happens on exactly those valid samples that have strobe=1, and dec_count is ignored.
- R6: In integrate-and-dump, an output is the sum of the valid samples since the previous dump. That sum includes the sample that triggered the previous dump and excludes the current one, which starts the next sum. No sample is lost or counted twice.
- R7: In integrator-comb mode, the value before scaling is the third difference, taken across successive dump instants, of the triple running sum of the valid samples received before each dump sample.
- R8: Scaling takes a value v and a shift s and gives floor((v + 2^(s-1)) / 2^s), which rounds ties upward. With s=0 the value is unchanged.
- R9: Scaled results above 511 give 511, and results below -512 give -512.
- R10: Accumulators are wide enough that dec_count=4096 with full-scale constant input gives an exact steady output of the input value when shift=36.
- R11: out_valid is a single-clock pulse one clock after the dump sample. Cycles with in_valid=0 change no filter state and produce no output.
- R12: Reset clears all filter and counter state, so a stream that restarts after reset gives the same outputs as one from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample pair is valid this cycle |
| in_i | input | 10 | In-phase sample, two's complement |
| in_q | input | 10 | Quadrature sample, two's complement |
| mode | input | 2 | Filter structure select (see R2) |
| use_strobe | input | 1 | 1: strobe sets output instants; 0: dec_count does |
| dec_count | input | 13 | Decimation factor, 1 to 4096 |
| shift | input | 6 | Right shift applied before rounding |
| strobe | input | 1 | Resampler carry marking an output sample |
| out_valid | output | 1 | One-clock pulse for a new output pair |
| out_i | output | 10 | Filtered in-phase output |
| out_q | output | 10 | Filtered quadrature output |

## Verification
The bench uses the default parameters: 10-bit samples, a 4096 decimation ceiling and 46-bit accumulators. At these sizes a full-scale constant stream can be run through the comb filter at the largest factor to show that the growth bound is met, in about sixteen thousand cycles. The same build allows a sweep of all 1024 input codes through the rounding path, and a sweep of factors 1 to 8 against several shifts in both filtering modes, with gaps in the valid flag and random strobes. Expected outputs come from exact 64-bit running sums.

// File: rtl/cic_pkg.sv
package cic_pkg;
    typedef enum logic [1:0] {
        MODE_CIC3     = 2'b00,
        MODE_DUMP     = 2'b01,
        MODE_PASS     = 2'b10,
        MODE_PASS_ALT = 2'b11
    } filt_mode_e;
endpackage

// File: rtl/cic_dec_ctrl.sv
module cic_dec_ctrl #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             use_strobe,
    input  logic             strobe,
    input  logic [CNT_W-1:0] dec_count,
    output logic             dump
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  hit;

    always_comb begin
        s_d  = s_q;
        hit  = use_strobe ? strobe : (s_q.cnt == (dec_count - ONE));
        dump = in_valid & hit;
        if (in_valid) begin
            s_d.cnt = hit ? '0 : s_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cic_scale.sv
module cic_scale #(
    parameter int ACC_W = 46,
    parameter int SH_W  = 6,
    parameter int OUT_W = 10
) (
    input  logic signed [ACC_W-1:0] v,
    input  logic        [SH_W-1:0]  sh,
    output logic signed [OUT_W-1:0] y
);
    localparam int EXT_W = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] MAXV = EXT_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [EXT_W-1:0] MINV = -MAXV - EXT_W'(1);

    logic signed [EXT_W-1:0] ext, half, rnd;

    always_comb begin
        ext  = {v[ACC_W-1], v};
        half = '0;
        if (sh != '0) begin
            half = EXT_W'(1) << (sh - SH_W'(1));
        end
        rnd = (ext + half) >>> sh;
        if (rnd > MAXV)      y = MAXV[OUT_W-1:0];
        else if (rnd < MINV) y = MINV[OUT_W-1:0];
        else                 y = rnd[OUT_W-1:0];
    end
endmodule

// File: rtl/cic_channel.sv
module cic_channel
    import cic_pkg::*;
#(
    parameter int IN_W  = 10,
    parameter int ACC_W = 46,
    parameter int SH_W  = 6,
    parameter int OUT_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    dump,
    input  logic [1:0]              mode,
    input  logic [SH_W-1:0]         sh,
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] y
);
    typedef struct packed {
        logic signed [ACC_W-1:0] i1;
        logic signed [ACC_W-1:0] i2;
        logic signed [ACC_W-1:0] i3;
        logic signed [ACC_W-1:0] d1;
        logic signed [ACC_W-1:0] d2;
        logic signed [ACC_W-1:0] d3;
        logic signed [ACC_W-1:0] acc;
        logic signed [OUT_W-1:0] y;
    } lane_t;

    lane_t s_d, s_q;
    logic signed [ACC_W-1:0] xe, c1, c2, c3, pick;
    logic        [SH_W-1:0]  sh_eff;
    logic signed [OUT_W-1:0] scaled;
    logic                    emit;

    cic_scale #(.ACC_W(ACC_W), .SH_W(SH_W), .OUT_W(OUT_W)) u_scale (
        .v  (pick),
        .sh (sh_eff),
        .y  (scaled)
    );

    always_comb begin
        xe = {{(ACC_W-IN_W){x[IN_W-1]}}, x};
        c1 = s_q.i3 - s_q.d1;
        c2 = c1 - s_q.d2;
        c3 = c2 - s_q.d3;
        case (mode)
            MODE_CIC3: begin pick = c3;     sh_eff = sh;  end
            MODE_DUMP: begin pick = s_q.acc; sh_eff = sh; end
            default:   begin pick = xe;     sh_eff = '0;  end
        endcase
        emit = mode[1] ? in_valid : dump;

        s_d = s_q;
        if (in_valid) begin
            s_d.i1  = s_q.i1 + xe;
            s_d.i2  = s_q.i2 + s_d.i1;
            s_d.i3  = s_q.i3 + s_d.i2;
            s_d.acc = dump ? xe : s_q.acc + xe;
        end
        if (dump) begin
            s_d.d1 = s_q.i3;
            s_d.d2 = c1;
            s_d.d3 = c2;
        end
        if (emit) s_d.y = scaled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign y = s_q.y;
endmodule

// File: rtl/cic_decim_top.sv
module cic_decim_top #(
    parameter int IN_W     = 10,
    parameter int OUT_W    = 10,
    parameter int DEC_LOG2 = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [IN_W-1:0]                   in_i,
    input  logic [IN_W-1:0]                   in_q,
    input  logic [1:0]                        mode,
    input  logic                              use_strobe,
    input  logic [DEC_LOG2:0]                 dec_count,
    input  logic [$clog2(IN_W+3*DEC_LOG2+1)-1:0] shift,
    input  logic                              strobe,
    output logic                              out_valid,
    output logic [OUT_W-1:0]                  out_i,
    output logic [OUT_W-1:0]                  out_q
);
    localparam int CNT_W = DEC_LOG2 + 1;
    localparam int ACC_W = IN_W + 3 * DEC_LOG2;
    localparam int SH_W  = $clog2(ACC_W + 1);
    localparam int LANES = 2;

    typedef struct packed {
        logic vld;
    } top_t;

    top_t s_d, s_q;
    logic dump;
    logic signed [IN_W-1:0]  lane_x [LANES];
    logic signed [OUT_W-1:0] lane_y [LANES];

    cic_dec_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .use_strobe (use_strobe),
        .strobe     (strobe),
        .dec_count  (dec_count),
        .dump       (dump)
    );

    assign lane_x[0] = in_i;
    assign lane_x[1] = in_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cic_channel #(.IN_W(IN_W), .ACC_W(ACC_W), .SH_W(SH_W), .OUT_W(OUT_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .dump     (dump),
            .mode     (mode),
            .sh       (shift),
            .x        (lane_x[g]),
            .y        (lane_y[g])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.vld = mode[1] ? in_valid : dump;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_i     = lane_y[0];
    assign out_q     = lane_y[1];
endmodule

// File: rtl/cic_decim_checker.sv
module cic_decim_checker #(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       mode,
    input logic             use_strobe,
    input logic [CNT_W-1:0] dec_count,
    input logic             strobe,
    input logic             out_valid
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_pass_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode[1])) |-> (out_valid == $past(in_valid)));

    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && out_valid) |-> $past(in_valid));

    assert_strobe_instant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(!mode[1] && use_strobe)) |-> (out_valid == $past(in_valid && strobe)));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && out_valid && !mode[1] && !use_strobe && dec_count > CNT_W'(1)
         && $stable(mode) && $stable(use_strobe)) |=> !out_valid);
endmodule

bind cic_decim_top cic_decim_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode       (mode),
    .use_strobe (use_strobe),
    .dec_count  (dec_count),
    .strobe     (strobe),
    .out_valid  (out_valid)
);

// File: tb/cic_decim_top_bench.sv
module cic_decim_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_i = '0, in_q = '0;
    logic [1:0]  mode = 2'b00;
    logic        use_strobe = 1'b0;
    logic [12:0] dec_count = 13'd1;
    logic [5:0]  shift = '0;
    logic        strobe = 1'b0;
    logic        out_valid;
    logic [9:0]  out_i, out_q;

    int checks = 0, errors = 0;
    bit done = 0;

    longint s1[2], s2[2], s3[2], d1[2], d2[2], d3[2], acc[2];
    int cnt;

    cic_decim_top u_cic_decim_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .mode(mode), .use_strobe(use_strobe), .dec_count(dec_count), .shift(shift),
        .strobe(strobe), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #10 clk = ~clk;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint scale_sat(longint v, int s);
        longint r;
        r = (s == 0) ? v : ((v + (64'sd1 <<< (s - 1))) >>> s);
        if (r > 511) r = 511;
        if (r < -512) r = -512;
        return r;
    endfunction

    task automatic model_clear();
        for (int l = 0; l < 2; l++) begin
            s1[l] = 0; s2[l] = 0; s3[l] = 0; d1[l] = 0; d2[l] = 0; d3[l] = 0; acc[l] = 0;
        end
        cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic step(bit v, int xi, int xq, bit st, string tag);
        bit     hit, ev;
        longint x[2], e[2], c1, c2, c3;
        x[0] = xi; x[1] = xq;
        in_valid = v; in_i = xi[9:0]; in_q = xq[9:0]; strobe = st;
        hit = use_strobe ? st : (cnt == int'(dec_count) - 1);
        e[0] = 0; e[1] = 0;
        if (mode[1]) begin
            ev = v; e[0] = x[0]; e[1] = x[1];
        end else begin
            ev = v && hit;
        end
        for (int l = 0; l < 2; l++) begin
            if (!mode[1] && ev) begin
                c1 = s3[l] - d1[l]; c2 = c1 - d2[l]; c3 = c2 - d3[l];
                e[l] = (mode == 2'b00) ? scale_sat(c3, int'(shift)) : scale_sat(acc[l], int'(shift));
                d1[l] = s3[l]; d2[l] = c1; d3[l] = c2;
            end
            if (v) begin
                s1[l] += x[l]; s2[l] += s1[l]; s3[l] += s2[l];
                acc[l] = (v && hit) ? x[l] : acc[l] + x[l];
            end
        end
        if (v) cnt = hit ? 0 : cnt + 1;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == ev, tag, "out_valid", out_valid, ev);
        if (ev) begin
            chk($signed(out_i) == e[0], tag, "out_i", $signed(out_i), e[0]);
            chk($signed(out_q) == e[1], tag, "out_q", $signed(out_q), e[1]);
        end
    endtask

    task automatic stream(int n, int gap_pct, string tag);
        for (int k = 0; k < n; k++) begin
            step($urandom_range(0, 99) >= gap_pct, int'($urandom_range(0, 1023)) - 512,
                 int'($urandom_range(0, 1023)) - 512, $urandom_range(0, 2) == 0, tag);
        end
    endtask

    task automatic setup(logic [1:0] m, int r, int s, bit us);
        mode = m; dec_count = 13'(r); shift = 6'(s); use_strobe = us;
        do_reset();
    endtask

    initial begin
        model_clear();
        // R1: reset state
        do_reset();
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(out_i == '0, "R1", "out_i", $signed(out_i), 0);
        chk(out_q == '0, "R1", "out_q", $signed(out_q), 0);

        // R3 / R2: pass-through in both encodings, other controls set but ignored
        setup(2'b10, 3, 7, 1'b0); stream(60, 30, "R3");
        setup(2'b11, 5, 9, 1'b1); stream(60, 30, "R2");

        // R6 and R7: factor sweep against several shifts
        for (int r = 1; r <= 8; r++) begin
            for (int si = 0; si < 3; si++) begin
                int sh_id, sh_cic;
                sh_id  = (si == 0) ? 0 : (si == 1) ? 3 : 9;
                sh_cic = (si == 0) ? 6 : (si == 1) ? 9 : 3 * $clog2(r);
                setup(2'b01, r, sh_id, 1'b0);  stream(r * 6 + 12, 20, "R6");
                setup(2'b00, r, sh_cic, 1'b0); stream(r * 8 + 12, 20, "R7");
            end
        end

        // R4: fixed count, constant input, first output on the count-th sample
        setup(2'b01, 5, 0, 1'b0);
        for (int k = 0; k < 25; k++) step(1'b1, 1, -2, 1'b1, "R4");

        // R8: every input code through the rounding path (factor 1 yields the prior sample)
        for (int s = 1; s <= 2; s++) begin
            setup(2'b01, 1, s, 1'b0);
            for (int c = -512; c <= 512; c++) step(1'b1, (c > 511) ? 0 : c, (c > 511) ? 0 : -1 - c, 1'b0, "R8");
        end

        // R9: comb filter with no shift saturates
        setup(2'b00, 8, 0, 1'b0); stream(60, 10, "R9");

        // R5: strobe-driven instants in both filtering modes
        setup(2'b01, 3, 2, 1'b1); stream(80, 20, "R5");
        setup(2'b00, 7, 4, 1'b1); stream(80, 20, "R5");

        // R11: long gaps in the valid flag
        setup(2'b00, 2, 3, 1'b0); stream(80, 70, "R11");

        // R10: largest factor, full scale both signs
        setup(2'b00, 4096, 36, 1'b0);
        for (int k = 0; k < 4 * 4096; k++) step(1'b1, -512, 511, 1'b0, "R10");
        setup(2'b01, 4096, 12, 1'b0);
        for (int k = 0; k < 2 * 4096 + 2; k++) step(1'b1, 511, -512, 1'b0, "R10");

        // R12: reset mid-stream restarts the windows
        setup(2'b01, 4, 0, 1'b0);
        for (int k = 0; k < 6; k++) step(1'b1, 100, -100, 1'b0, "R12");
        do_reset();
        for (int k = 0; k < 12; k++) step(1'b1, 7, 3, 1'b0, "R12");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule